// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits at the front of the private peripheral window of a cluster of one to four cores. A simple request-style register bus presents an address inside an 8 KiB window. The block answers the snoop-control register bank itself. Accesses meant for the per-core interrupt-controller CPU interfaces, the private timers, the watchdogs and the interrupt distributor are passed on as one-hot selects, each with an offset relative to its own sub-window. Addresses that map to nothing get an error response from the block.

The block also watches one timer line and one watchdog line per core. Each low-to-high transition becomes a single-cycle set-pending request for the interrupt controller. The request carries the owning core number and the private interrupt ID. When several lines rise together, their requests are queued and issued one per cycle.

Top module: `priv_win_dec`

## Requirements
- R1: The control register is at byte offset 0x00. A write keeps data bit 0. A read returns the kept bit in bit 0, with all other bits zero.
- R2: A read of offset 0x04 returns the configuration word. Bits [3:0] hold (NUM_CORES-1). Bits starting at bit 4 hold a mask of NUM_CORES ones. The word is read-only.
- R3: Offsets 0x08 and 0x0C read as zero. A write to 0x0C completes without error and changes no register.
- R4: Inside 0x000-0x0FF, the following are errors: a read of any offset other than 0x00/0x04/0x08/0x0C, and a write to any offset other than 0x00/0x0C. An error response always has read data zero. Only address bits [7:0] pick the register inside this range.
- R5: Addresses from 0x100 up to 0x100+(NUM_CORES+1)*0x100-1 select CPU-interface window j = addr[11:8]-1. Window 0 is the current-core alias and window 1+c is core c. The forwarded offset is addr[7:0].
- R6: For j in 0..NUM_CORES, 0x600+j*0x100..+0x1F selects timer j, and 0x620+j*0x100..+0x1F selects watchdog j. In both cases the forwarded offset is addr[4:0].
- R7: Addresses 0x1000-0x1FFF select the distributor, with forwarded offset addr[11:0].
- R8: Any other address with addr >= 0x100 is a hole. A hole gets an error response with read data zero and drives no select.
- R9: Line k = 2*core + (0 timer, 1 watchdog). A low-to-high change of line k, seen against its stored previous level, gives exactly one pend_vld_o pulse with core k>>1 and ID 29 (timer) or 30 (watchdog). A line held high or falling gives no pulse.
- R10: Lines that rise in the same cycle are issued on consecutive cycles, in ascending k.
- R11: Reset clears the control bit and all stored line levels. While reset is held, no response and no pulse are asserted.
- R12: Selects and forwarded offsets follow req_i and addr_i in the same cycle. A forwarded access gets no local response. A local access (snoop-control or hole) gets rsp_vld_o exactly one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| rsp_vld_o | output | 1 | Local response valid |
| rsp_err_o | output | 1 | Local response is an error |
| rsp_rdata_o | output | 32 | Local read data |
| cpuif_sel_o | output | NUM_CORES+1 | CPU-interface window selects (bit 0 = alias) |
| tmr_sel_o | output | NUM_CORES+1 | Timer window selects |
| wdt_sel_o | output | NUM_CORES+1 | Watchdog window selects |
| dist_sel_o | output | 1 | Distributor select |
| fwd_offs_o | output | 12 | Offset inside the selected forwarded window |
| irq_lvl_i | input | 2*NUM_CORES | Timer/watchdog interrupt levels |
| pend_vld_o | output | 1 | Set-pending pulse |
| pend_core_o | output | 2 | Target core of the pulse |
| pend_id_o | output | 5 | Interrupt ID of the pulse |

## Verification
Selects and forwarded offsets are combinational. The bench checks them one time unit after it drives a request, before the clock edge. The local response passes through one register. It is sampled at the falling edge that follows the capturing rising edge, and the request is dropped at that point so that each access is counted once. Set-pending pulses also pass through one register. After a level change at a falling edge, the first pulse is expected at the next falling edge, and any further ones are expected on each later falling edge in ascending line order. The sweep then confirms one quiet cycle after the last pulse.

// File: rtl/priv_win_pkg.sv
`timescale 1ns/1ps
package priv_win_pkg;
  localparam int unsigned CORE_W   = 2;
  localparam int unsigned IRQ_ID_W = 5;
  localparam int unsigned TMR_ID   = 29;
  localparam int unsigned WDT_ID   = 30;
  localparam logic [3:0]  PG_CPUIF = 4'd1;
  localparam logic [3:0]  PG_TMR   = 4'd6;

  typedef enum logic [2:0] {
    WIN_NONE, WIN_SCU, WIN_CPUIF, WIN_TMR, WIN_WDT, WIN_DIST
  } win_e;
endpackage

// File: rtl/priv_addr_dec.sv
`timescale 1ns/1ps
module priv_addr_dec
  import priv_win_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [12:0] addr_i,
  output win_e        win_o,
  output logic [2:0]  idx_o,
  output logic [11:0] offs_o
);
  localparam logic [3:0] CPUIF_LAST = 4'(PG_CPUIF + NUM_CORES);
  localparam logic [3:0] TMR_LAST   = 4'(PG_TMR + NUM_CORES);

  logic [3:0] page;
  assign page = addr_i[11:8];

  always_comb begin
    win_o  = WIN_NONE;
    idx_o  = '0;
    offs_o = '0;
    if (addr_i[12]) begin
      win_o  = WIN_DIST;
      offs_o = addr_i[11:0];
    end else if (page == 4'd0) begin
      win_o = WIN_SCU;
    end else if (page <= CPUIF_LAST) begin
      win_o  = WIN_CPUIF;
      idx_o  = 3'(page - PG_CPUIF);
      offs_o = {4'd0, addr_i[7:0]};
    end else if (page >= PG_TMR && page <= TMR_LAST) begin
      idx_o = 3'(page - PG_TMR);
      // timer at +0x00, watchdog at +0x20, rest of page unmapped
      if (addr_i[7:5] == 3'd0) begin
        win_o  = WIN_TMR;
        offs_o = {7'd0, addr_i[4:0]};
      end else if (addr_i[7:5] == 3'd1) begin
        win_o  = WIN_WDT;
        offs_o = {7'd0, addr_i[4:0]};
      end
    end
  end
endmodule

// File: rtl/priv_scu_regs.sv
`timescale 1ns/1ps
module priv_scu_regs #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              hole_i,
  input  logic              we_i,
  input  logic [7:0]        offs_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_vld_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'(((32'd1 << NUM_CORES) - 32'd1) << 4) | DATA_W'(NUM_CORES - 1);

  logic              ctrl_q;
  logic [DATA_W-1:0] rd;
  logic              err;

  always_comb begin
    rd  = '0;
    err = 1'b0;
    if (hole_i) begin
      err = 1'b1;
    end else if (we_i) begin
      case (offs_i)
        8'h00, 8'h0C: err = 1'b0;
        default:      err = 1'b1;
      endcase
    end else begin
      case (offs_i)
        8'h00:        rd = {{(DATA_W-1){1'b0}}, ctrl_q};
        8'h04:        rd = CFG_WORD;
        8'h08, 8'h0C: rd = '0;
        default:      err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= 1'b0;
      rsp_vld_o   <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_vld_o   <= acc_i | hole_i;
      rsp_err_o   <= (acc_i | hole_i) & err;
      rsp_rdata_o <= ((acc_i | hole_i) && !err) ? rd : '0;
      if (acc_i && we_i && offs_i == 8'h00) ctrl_q <= wdata_i[0];
    end
  end
endmodule

// File: rtl/priv_irq_edge.sv
`timescale 1ns/1ps
module priv_irq_edge
  import priv_win_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lvl_i,
  output logic                 vld_o,
  output logic [CORE_W-1:0]    core_o,
  output logic [IRQ_ID_W-1:0]  id_o
);
  localparam int unsigned KW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [NUM_LINES-1:0] prev_q, pend_q, merged, grant;
  logic [KW-1:0]        gidx;
  logic                 found;

  always_comb begin
    merged = pend_q | (lvl_i & ~prev_q);
    grant  = '0;
    gidx   = '0;
    found  = 1'b0;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (merged[k] && !found) begin
        found    = 1'b1;
        grant[k] = 1'b1;
        gidx     = KW'(k);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
      vld_o  <= 1'b0;
      core_o <= '0;
      id_o   <= '0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= merged & ~grant;
      vld_o  <= found;
      core_o <= CORE_W'(gidx >> 1);
      id_o   <= gidx[0] ? IRQ_ID_W'(WDT_ID) : IRQ_ID_W'(TMR_ID);
    end
  end
endmodule

// File: rtl/priv_win_dec.sv
`timescale 1ns/1ps
module priv_win_dec
  import priv_win_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NWIN     = NUM_CORES + 1,
  localparam int unsigned NLINE    = 2 * NUM_CORES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [12:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rsp_vld_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [NWIN-1:0]   cpuif_sel_o,
  output logic [NWIN-1:0]   tmr_sel_o,
  output logic [NWIN-1:0]   wdt_sel_o,
  output logic              dist_sel_o,
  output logic [11:0]       fwd_offs_o,
  input  logic [NLINE-1:0]  irq_lvl_i,
  output logic              pend_vld_o,
  output logic [1:0]        pend_core_o,
  output logic [4:0]        pend_id_o
);
  win_e        win;
  logic [2:0]  idx;
  logic [11:0] offs;
  logic        fwd;

  priv_addr_dec #(.NUM_CORES(NUM_CORES)) u_dec (
    .addr_i (addr_i),
    .win_o  (win),
    .idx_o  (idx),
    .offs_o (offs)
  );

  for (genvar j = 0; j < NWIN; j++) begin : g_sel
    assign cpuif_sel_o[j] = req_i && win == WIN_CPUIF && idx == 3'(j);
    assign tmr_sel_o[j]   = req_i && win == WIN_TMR   && idx == 3'(j);
    assign wdt_sel_o[j]   = req_i && win == WIN_WDT   && idx == 3'(j);
  end
  assign dist_sel_o = req_i && win == WIN_DIST;
  assign fwd        = (|cpuif_sel_o) | (|tmr_sel_o) | (|wdt_sel_o) | dist_sel_o;
  assign fwd_offs_o = fwd ? offs : '0;

  priv_scu_regs #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_scu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (req_i && win == WIN_SCU),
    .hole_i      (req_i && win == WIN_NONE),
    .we_i        (we_i),
    .offs_i      (addr_i[7:0]),
    .wdata_i     (wdata_i),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  priv_irq_edge #(.NUM_LINES(NLINE)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_lvl_i),
    .vld_o  (pend_vld_o),
    .core_o (pend_core_o),
    .id_o   (pend_id_o)
  );
endmodule

// File: rtl/priv_win_chk.sv
`timescale 1ns/1ps
module priv_win_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NWIN     = NUM_CORES + 1,
  localparam int unsigned NLINE    = 2 * NUM_CORES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [12:0]       addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rsp_vld_o,
  input logic              rsp_err_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic [NWIN-1:0]   cpuif_sel_o,
  input logic [NWIN-1:0]   tmr_sel_o,
  input logic [NWIN-1:0]   wdt_sel_o,
  input logic              dist_sel_o,
  input logic [11:0]       fwd_offs_o,
  input logic [NLINE-1:0]  irq_lvl_i,
  input logic              pend_vld_o,
  input logic [1:0]        pend_core_o,
  input logic [4:0]        pend_id_o
);
  logic any_fwd;
  assign any_fwd = (|cpuif_sel_o) | (|tmr_sel_o) | (|wdt_sel_o) | dist_sel_o;

  // R4
  err_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_rdata_o == '0);

  // R9
  pend_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o |-> (pend_id_o == 5'd29 || pend_id_o == 5'd30));

  // R9
  pend_core_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_o |-> 32'(pend_core_o) < NUM_CORES);

  // R12
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpuif_sel_o, tmr_sel_o, wdt_sel_o, dist_sel_o}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_vld_o);

  // R12
  fwd_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_fwd |=> !rsp_vld_o);

  // R7
  dist_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dist_sel_o |-> (req_i && addr_i[12]));

  // R8
  no_sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !any_fwd);
endmodule

bind priv_win_dec priv_win_chk #(.NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/priv_win_dec_test.sv
`timescale 1ns/1ps
module priv_win_dec_test;
  localparam int N  = 4;
  localparam int NW = N + 1;
  localparam int NL = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rsp_vld, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NW-1:0] cpuif_sel, tmr_sel, wdt_sel;
  logic dist_sel;
  logic [11:0] fwd_offs;
  logic [NL-1:0] lvl = '0;
  logic pend_vld;
  logic [1:0] pend_core;
  logic [4:0] pend_id;

  int n_run = 0, n_fail = 0;
  logic ctrl_m = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  priv_win_dec #(.NUM_CORES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rsp_vld_o(rsp_vld), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .cpuif_sel_o(cpuif_sel), .tmr_sel_o(tmr_sel),
    .wdt_sel_o(wdt_sel), .dist_sel_o(dist_sel), .fwd_offs_o(fwd_offs),
    .irq_lvl_i(lvl), .pend_vld_o(pend_vld), .pend_core_o(pend_core),
    .pend_id_o(pend_id)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input int a, input logic [31:0] d);
    logic [NW-1:0] ec, et, ew;
    logic ed, loc, eerr;
    logic [11:0] eo;
    logic [31:0] erd;
    int off;
    string tag;
    @(negedge clk);
    req = 1'b1; we = w; addr = a[12:0]; wdata = d;
    ec = '0; et = '0; ew = '0; ed = 1'b0; eo = '0; loc = 1'b0; eerr = 1'b0;
    erd = '0; tag = "R8";
    if (a >= 4096) begin
      ed = 1'b1; eo = 12'(a - 4096); tag = "R7";
    end else if (a < 256) begin
      loc = 1'b1; off = a % 256;
      if (off == 0) tag = "R1";
      else if (off == 4) tag = "R2";
      else if (off == 8 || off == 12) tag = "R3";
      else tag = "R4";
      if (w) begin
        eerr = !(off == 0 || off == 12);
        if (w && off == 0 && !eerr) tag = "R1";
      end else begin
        if (off == 0) erd = {31'd0, ctrl_m};
        else if (off == 4) erd = (((1 << N) - 1) << 4) | (N - 1);
        else if (off == 8 || off == 12) erd = 0;
        else eerr = 1'b1;
      end
      if (eerr) tag = "R4";
    end else if (a < 256 * (N + 2)) begin
      ec[a / 256 - 1] = 1'b1; eo = 12'(a % 256); tag = "R5";
    end else if (a >= 1536 && a < 1536 + 256 * (N + 1) && (a % 256) < 64) begin
      if ((a % 256) < 32) et[(a - 1536) / 256] = 1'b1;
      else ew[(a - 1536) / 256] = 1'b1;
      eo = 12'(a % 32); tag = "R6";
    end else begin
      loc = 1'b1; eerr = 1'b1; tag = "R8";
    end
    #1;
    chk({cpuif_sel, tmr_sel, wdt_sel, dist_sel} == {ec, et, ew, ed},
        {tag, " sel"}, 32'({cpuif_sel, tmr_sel, wdt_sel, dist_sel}),
        32'({ec, et, ew, ed}));
    chk(fwd_offs == eo, {tag, " offs"}, 32'(fwd_offs), 32'(eo));
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    if (w && a < 256 && (a % 256) == 0) ctrl_m = d[0];
    chk(rsp_vld == loc, "R12 rsp_vld", 32'(rsp_vld), 32'(loc));
    if (loc) begin
      chk(rsp_err == eerr, {tag, " err"}, 32'(rsp_err), 32'(eerr));
      chk(rsp_rdata == erd, {tag, " rdata"}, rsp_rdata, erd);
    end
  endtask

  task automatic irq_pat(input int p);
    @(negedge clk);
    lvl = '0;
    @(negedge clk);
    chk(!pend_vld, "R9 fall quiet", 32'(pend_vld), 0);
    lvl = NL'(p);
    for (int k = 0; k < NL; k++) begin
      if (p[k]) begin
        @(negedge clk);
        chk(pend_vld && pend_core == 2'(k / 2) && pend_id == 5'(29 + k % 2),
            (p == (1 << k)) ? "R9 pulse" : "R10 order",
            {23'd0, pend_vld, pend_core, pend_id},
            {23'd0, 1'b1, 2'(k / 2), 5'(29 + k % 2)});
      end
    end
    @(negedge clk);
    chk(!pend_vld, "R9 hold quiet", 32'(pend_vld), 0);
    @(negedge clk);
    chk(!pend_vld, "R9 hold quiet", 32'(pend_vld), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    lvl = 8'h09;
    repeat (3) @(negedge clk);
    chk(!rsp_vld && !pend_vld, "R11 reset quiet", {rsp_vld, pend_vld}, 0);
    lvl = '0;
    @(negedge clk);
    rst_n = 1'b1;
    acc(1'b0, 0, '0);
    // R11 control starts at zero, R1 write/read
    acc(1'b1, 0, 32'hFFFF_FFFF);
    acc(1'b0, 0, '0);
    // R3 invalidate write leaves control and config intact
    acc(1'b1, 12, 32'hFFFF_FFFF);
    acc(1'b0, 0, '0);
    acc(1'b1, 4, 32'h0);
    acc(1'b0, 4, '0);
    acc(1'b1, 0, 32'hFFFF_FFFE);
    acc(1'b0, 0, '0);
    // R4 only low byte used inside snoop-control range
    for (int a = 0; a < 256; a++) begin
      acc(1'b1, a, {a[7:0], ~a[7:0], a[7:0], a[7:0] ^ 8'h5A});
      acc(1'b0, a, '0);
    end
    // R5-R8 full address sweep
    for (int a = 256; a < 8192; a++) acc(1'b0, a, '0);
    for (int a = 256; a < 8192; a += 97) acc(1'b1, a, 32'hA5A5_0001);
    // R9/R10 every line pattern
    for (int p = 1; p < (1 << NL); p++) irq_pat(p);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule